// File: doc/BRIEF.md
# Burst-to-Strobe Rate Synchronizer

This block takes 32-bit results that arrive in bursts on the 100 MHz fabric clock and hands them to a downstream sample path. That path advances only on a periodic tick at the radio sample rate. Each incoming word is qualified by a valid input and is stored in a first-in first-out buffer. The buffer holds at least one full 1024-bin spectrum frame, so a whole frame can land back-to-back without loss.

The sample rate must divide the fabric clock by an integer. The pacing tick is therefore a single-cycle pulse that repeats every N clocks. On each tick that finds the buffer holding data, the block pops one word and raises its own output strobe one cycle later. The word sits in the receive sample slot, so the logic downstream sees an ordinary receive stream. Between strobes the output word does not move.

A word that arrives while the buffer is full is discarded, and a sticky overflow flag records the loss until it is cleared.

Top module: `pace_sync`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `out_stb` and `ovf_sticky` are 0, `out_data` is 0 and the buffer is empty. Words written before a reset never come out afterwards.
- R2: `out_stb` is high in cycle t+1 exactly when `pace_tick` was high in cycle t and the buffer held at least one word before the edge ending cycle t. A word written in that same cycle t does not count.
- R3: `out_data` changes only in a cycle where `out_stb` is high. In all other cycles it keeps its previous value.
- R4: Accepted words appear on `out_data` in arrival order, each exactly once, one word per `out_stb` pulse.
- R5: The buffer accepts words while it holds fewer than DEPTH words (default 1024), and all DEPTH stored words are later delivered.
- R6: A word with `in_vld` high that arrives while the buffer holds DEPTH words is dropped, and `ovf_sticky` is 1 from the next cycle on. The flag stays 1 until a clear.
- R7: `ovf_clr` high sets `ovf_sticky` to 0 in the next cycle, unless a drop happens in the same cycle. A drop takes priority over a clear.
- R8: When `in_vld` is low, `in_data` is ignored and nothing is stored.
- R9: All 32 bits pass unchanged. Bit 31 (the detection flag) and bits 30:0 (the power value) come out exactly as they went in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Qualifies `in_data` for storage |
| in_data | input | WORD_W | Result word: bit 31 flag, bits 30:0 power |
| pace_tick | input | 1 | Sample-rate tick, one pulse every N clocks |
| ovf_clr | input | 1 | Synchronous clear of the overflow flag |
| out_data | output | WORD_W | Word in the sample slot, held between strobes |
| out_stb | output | 1 | Marks a new word on `out_data` |
| ovf_sticky | output | 1 | Set when a word was dropped on a full buffer |

## Verification
The properties take for granted that reset is high from time zero for at least one edge. They also assume every input is driven to a known level and changes only away from the rising edge. They do not assume the tick is periodic: they relate each strobe only to the tick one cycle earlier and to the fill level seen then. The stimulus drives all inputs on the falling edge and holds reset high from the start. It uses tick periods of one to four clocks and crosses the full-buffer boundary with writes, clears and drains, so every fill-level corner is visited.

// File: rtl/pace_sync_pkg.sv
package pace_sync_pkg;

  // Per-cycle buffer events decided by the controller
  typedef struct packed {
    logic push;  // word is written into storage
    logic pop;   // word is read out toward the sample slot
    logic drop;  // valid word lost because storage was full
  } fifo_evt_t;

  localparam int DEF_WORD_W = 32;
  localparam int DEF_DEPTH  = 1024;

endpackage

// File: rtl/pace_ram.sv
// Simple dual-port storage with registered, enabled read (block RAM style)
module pace_ram #(
  parameter int W  = 32,
  parameter int N  = 1024,
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic          re,
  input  logic [AW-1:0] ra,
  output logic [W-1:0]  rd
);

  logic [W-1:0] mem [N];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end

  // Output register only loads on a pop, so the value holds between strobes
  always_ff @(posedge clk) begin
    if (rst)     rd <= '0;
    else if (re) rd <= mem[ra];
  end

endmodule

// File: rtl/pace_fifo_ctrl.sv
// Pointer and fill-level bookkeeping; full/empty judged on the pre-edge level
module pace_fifo_ctrl
  import pace_sync_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int AW    = 10,
  parameter int CW    = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_req,
  input  logic          pop_req,
  output fifo_evt_t     evt,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic [CW-1:0] level
);

  localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);
  localparam logic [AW-1:0] LAST     = AW'(DEPTH - 1);

  logic full, empty;

  assign full  = (level == FULL_LVL);
  assign empty = (level == '0);

  always_comb begin
    evt.push = push_req && !full;
    evt.pop  = pop_req  && !empty;
    evt.drop = push_req && full;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (evt.push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (evt.pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({evt.push, evt.pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

endmodule

// File: rtl/pace_flags.sv
// Output strobe register and sticky overflow flag
module pace_flags
  import pace_sync_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      ovf_clr,
  input  fifo_evt_t evt,
  output logic      out_stb,
  output logic      ovf_sticky
);

  always_ff @(posedge clk) begin
    if (rst) out_stb <= 1'b0;
    else     out_stb <= evt.pop;
  end

  // A drop in the same cycle wins over a clear
  always_ff @(posedge clk) begin
    if (rst)          ovf_sticky <= 1'b0;
    else if (evt.drop) ovf_sticky <= 1'b1;
    else if (ovf_clr)  ovf_sticky <= 1'b0;
  end

endmodule

// File: rtl/pace_sync.sv
module pace_sync
  import pace_sync_pkg::*;
#(
  parameter int WORD_W = DEF_WORD_W,
  parameter int DEPTH  = DEF_DEPTH
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_vld,
  input  logic [WORD_W-1:0] in_data,
  input  logic              pace_tick,
  input  logic              ovf_clr,
  output logic [WORD_W-1:0] out_data,
  output logic              out_stb,
  output logic              ovf_sticky
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  fifo_evt_t     evt;
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;
  logic [CW-1:0] level;

  pace_fifo_ctrl #(
    .DEPTH (DEPTH),
    .AW    (AW),
    .CW    (CW)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .push_req (in_vld),
    .pop_req  (pace_tick),
    .evt      (evt),
    .wr_ptr   (wr_ptr),
    .rd_ptr   (rd_ptr),
    .level    (level)
  );

  pace_ram #(
    .W  (WORD_W),
    .N  (DEPTH),
    .AW (AW)
  ) u_ram (
    .clk (clk),
    .rst (rst),
    .we  (evt.push),
    .wa  (wr_ptr),
    .wd  (in_data),
    .re  (evt.pop),
    .ra  (rd_ptr),
    .rd  (out_data)
  );

  pace_flags u_flags (
    .clk        (clk),
    .rst        (rst),
    .ovf_clr    (ovf_clr),
    .evt        (evt),
    .out_stb    (out_stb),
    .ovf_sticky (ovf_sticky)
  );

endmodule

// File: rtl/pace_sync_chk.sv
module pace_sync_chk #(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 1024
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         in_vld,
  input logic                         pace_tick,
  input logic                         ovf_clr,
  input logic [WORD_W-1:0]            out_data,
  input logic                         out_stb,
  input logic                         ovf_sticky,
  input logic [$clog2(DEPTH+1)-1:0]   level
);

  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (!out_stb && !ovf_sticky && level == '0 && out_data == '0));

  // R2
  stb_from_tick_chk: assert property (@(posedge clk) disable iff (rst)
    out_stb |-> $past(pace_tick));

  // R2
  empty_no_stb_chk: assert property (@(posedge clk) disable iff (rst)
    (pace_tick && level == '0) |=> !out_stb);

  // R2
  tick_pops_chk: assert property (@(posedge clk) disable iff (rst)
    (pace_tick && level != '0) |=> out_stb);

  // R3
  hold_data_chk: assert property (@(posedge clk) disable iff (rst)
    (!out_stb && !$past(rst)) |-> $stable(out_data));

  // R5
  fill_up_chk: assert property (@(posedge clk) disable iff (rst)
    (in_vld && level < FULL_LVL && !(pace_tick && level != '0)) |=> level == $past(level) + 1'b1);

  // R6
  ovf_set_chk: assert property (@(posedge clk) disable iff (rst)
    (in_vld && level == FULL_LVL) |=> ovf_sticky);

  // R6
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf_sticky && !ovf_clr) |=> ovf_sticky);

  // R7
  ovf_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf_clr && !(in_vld && level == FULL_LVL)) |=> !ovf_sticky);

endmodule

bind pace_sync pace_sync_chk #(
  .WORD_W (WORD_W),
  .DEPTH  (DEPTH)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_vld     (in_vld),
  .pace_tick  (pace_tick),
  .ovf_clr    (ovf_clr),
  .out_data   (out_data),
  .out_stb    (out_stb),
  .ovf_sticky (ovf_sticky),
  .level      (level)
);

// File: tb/pace_sync_bench.sv
module pace_sync_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 1024;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_vld = 1'b0;
  logic [31:0] in_data = '0;
  logic        pace_tick = 1'b0;
  logic        ovf_clr = 1'b0;
  logic [31:0] out_data;
  logic        out_stb;
  logic        ovf_sticky;

  int n_chk  = 0;
  int n_fail = 0;
  int n_out  = 0;
  string cur = "R1";

  logic [31:0] mq [$];
  logic [31:0] m_word = '0;
  logic        m_stb  = 1'b0;
  logic        m_ovf  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pace_sync #(.WORD_W(32), .DEPTH(DEPTH)) u_pace_sync (
    .clk        (clk),
    .rst        (rst),
    .in_vld     (in_vld),
    .in_data    (in_data),
    .pace_tick  (pace_tick),
    .ovf_clr    (ovf_clr),
    .out_data   (out_data),
    .out_stb    (out_stb),
    .ovf_sticky (ovf_sticky)
  );

  function automatic logic [31:0] word_of(input int i);
    logic [31:0] w;
    w = (i * 32'h0001_0203) + 32'd5;
    w[31] = i[0];
    return w;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s (phase %s) %s actual=%h expected=%h", req, cur, what, act, exp);
    end
  endtask

  // One clock: model computes next state from pre-edge state, DUT sampled at negedge
  task automatic step(input logic v, input logic [31:0] w, input logic s, input logic c);
    int  pre;
    logic drop;
    in_vld = v; in_data = w; pace_tick = s; ovf_clr = c;
    pre   = mq.size();
    m_stb = s && (pre > 0);
    if (m_stb) m_word = mq.pop_front();
    drop = v && (pre == DEPTH);
    if (v && !drop) mq.push_back(w);
    if (drop)   m_ovf = 1'b1;
    else if (c) m_ovf = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R2", "out_stb",    {31'd0, out_stb},    {31'd0, m_stb});
    chk("R4", "out_data",   out_data,             m_word);
    chk("R6", "ovf_sticky", {31'd0, ovf_sticky}, {31'd0, m_ovf});
    if (out_stb) n_out++;
  endtask

  task automatic do_reset();
    rst = 1'b1; in_vld = 1'b0; pace_tick = 1'b0; ovf_clr = 1'b0; in_data = '0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    rst = 1'b0;
    mq.delete();
    m_word = '0; m_stb = 1'b0; m_ovf = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    // R1: reset state and empty buffer
    cur = "R1";
    do_reset();
    chk("R1", "out_stb after reset",    {31'd0, out_stb},    32'd0);
    chk("R1", "out_data after reset",   out_data,             32'd0);
    chk("R1", "ovf_sticky after reset", {31'd0, ovf_sticky}, 32'd0);
    step(1'b0, '0, 1'b1, 1'b0);

    // R4 / R9: burst with tick period 4, words with both flag values
    cur = "R9";
    for (int i = 0; i < 24; i++) step(1'b1, word_of(i), (i % 4) == 3, 1'b0);
    for (int k = 0; k < 120; k++) step(1'b0, '0, (k % 4) == 3, 1'b0);

    // R2: write and tick in the same cycle on an empty buffer
    cur = "R2";
    step(1'b1, 32'hA5A5_0001, 1'b1, 1'b0);
    step(1'b0, '0, 1'b1, 1'b0);
    step(1'b0, '0, 1'b0, 1'b0);

    // R8: valid gaps with junk on the data lines, tick period 3
    cur = "R8";
    for (int i = 0; i < 40; i++)
      step((i % 3) == 0, ((i % 3) == 0) ? word_of(100 + i) : (32'hDEAD_0000 | i),
           (i % 3) == 1, 1'b0);
    for (int k = 0; k < 60; k++) step(1'b0, 32'hBEEF_0000 | k, (k % 3) == 2, 1'b0);

    // R3: hold across a long gap, then tick period 1
    cur = "R3";
    step(1'b1, 32'h8000_1234, 1'b0, 1'b0);
    step(1'b1, 32'h0000_5678, 1'b1, 1'b0);
    for (int k = 0; k < 12; k++) step(1'b0, '0, 1'b0, 1'b0);
    for (int k = 0; k < 4; k++)  step(1'b0, '0, 1'b1, 1'b0);

    // R5: fill to DEPTH with no ticks
    cur = "R5";
    for (int i = 0; i < DEPTH; i++) step(1'b1, word_of(1000 + i), 1'b0, 1'b0);
    chk("R5", "no overflow at exactly DEPTH", {31'd0, ovf_sticky}, 32'd0);

    // R6: writes on a full buffer are lost
    cur = "R6";
    for (int i = 0; i < 3; i++) step(1'b1, 32'hFFFF_FFF0 + i, 1'b0, 1'b0);
    chk("R6", "overflow flagged", {31'd0, ovf_sticky}, 32'd1);

    // R7: drop beats clear, flag sticky, plain clear works
    cur = "R7";
    step(1'b1, 32'h7777_7777, 1'b0, 1'b1);
    chk("R7", "drop wins over clear", {31'd0, ovf_sticky}, 32'd1);
    step(1'b0, '0, 1'b0, 1'b0);
    step(1'b0, '0, 1'b0, 1'b1);
    chk("R7", "clear takes effect", {31'd0, ovf_sticky}, 32'd0);

    // R5: drain everything with tick period 2
    cur = "R5";
    n_out = 0;
    for (int k = 0; k < 2 * DEPTH + 10; k++) step(1'b0, '0, (k % 2) == 1, 1'b0);
    chk("R5", "words delivered after full fill", n_out, DEPTH);

    // R1: reset in mid-stream discards stored words
    cur = "R1";
    for (int i = 0; i < 5; i++) step(1'b1, word_of(3000 + i), 1'b0, 1'b0);
    do_reset();
    chk("R1", "out_data after mid reset", out_data, 32'd0);
    n_out = 0;
    for (int k = 0; k < 10; k++) step(1'b0, '0, 1'b1, 1'b0);
    chk("R1", "no words after mid reset", n_out, 0);

    summary();
    $finish;
  end

endmodule